// File: doc/BRIEF.md
# Exception Entry Unit

This block performs the state changes a processor makes on the clock edge where an exception is taken. The pipeline gives it a one-cycle strobe together with the exception code, the coprocessor number, the PC of the faulting instruction, a delay-slot flag, a translation error class, the access direction, the faulting virtual address and the mode bits of the status register. On that edge the block updates the exception program counter, the exception-level flag, the cause fields and the translation fault registers. It also presents the handler address together with a one-cycle load pulse.

The exception code written to the cause register comes from the translation error class when that class is set. Otherwise it comes from the code input. Translation refill faults choose one of three handler addresses. The choice depends on the exception level before entry, on whether the error was an invalid entry, and on whether the faulting region uses wide (64-bit) addressing. Every other exception goes to the general handler. When boot vectors are selected, the block flags an error and does not load the PC. The exception level is held here and is cleared by a separate input when the handler returns.

Top module: `exc_entry`

## Requirements
- R1: After reset, `exl`, `epc`, `cause_bd`, `cause_code`, `cause_ce`, `badvaddr`, all context fields, `pc_load`, `new_pc` and `bev_err` are zero.
- R2: A strobe taken while `exl` is 0 loads `cause_bd` from `exc_in_delay` and loads `epc` with `exc_pc`, or with `exc_pc - 4` when the delay flag is set. It also sets `exl`. All of these are visible after that clock edge.
- R3: A strobe taken while `exl` is 1 leaves `epc` and `cause_bd` unchanged. It still overwrites `cause_code` and `cause_ce` (from `exc_cop`).
- R4: `tlb_err` encodes 0 none, 1 miss, 2 invalid, 3 modification and 4 disallowed address. Values 5 to 7 behave like 0. With no error class, `cause_code` takes `exc_code`.
- R5: Miss and invalid give code 2 for a load and code 3 for a store (`acc_store` = 1).
- R6: Modification gives code 1. A disallowed address gives code 4 for a load and code 5 for a store.
- R7: Any final code other than 2 or 3 selects handler address 0xFFFFFFFF_80000180.
- R8: Code 2 or 3 selects 0xFFFFFFFF_80000180 when `exl` was already set or when the error class is invalid.
- R9: Otherwise code 2 or 3 selects 0xFFFFFFFF_80000080 when the faulting region uses wide addressing, and 0xFFFFFFFF_80000000 when it does not. `fault_va[63:62]` picks the region: 00 follows `sr_ux`, 01 follows `sr_sx`, 11 follows `sr_kx`, and 10 is never wide.
- R10: With an error class of 1 to 4, `badvaddr` takes `fault_va`. `ctx_vpn2` takes `fault_va[31:13]`. `xctx_vpn2` and `ehi_vpn2` take `fault_va[39:13]`. `xctx_region` and `ehi_region` take `fault_va[63:62]`.
- R11: With no error class, the fault registers of R10 keep their values.
- R12: With `sr_bev` = 1, the strobe raises `bev_err` for one cycle and `pc_load` stays low. The updates of R2 to R6 and R10 still happen.
- R13: With `sr_bev` = 0, `pc_load` is high for exactly the one cycle after the strobe edge, and `new_pc` then holds the selected address.
- R14: `exl_clr` clears `exl` on the next edge unless a strobe arrives in the same cycle, in which case the strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_valid | input | 1 | One-cycle exception strobe |
| exc_code | input | CODE_W (5) | Exception code used when no error class is given |
| exc_cop | input | 2 | Coprocessor number for the cause register |
| exc_pc | input | XLEN (64) | PC of the faulting instruction |
| exc_in_delay | input | 1 | Instruction sat in a branch delay slot |
| tlb_err | input | 3 | Translation error class |
| acc_store | input | 1 | Faulting access was a store |
| fault_va | input | XLEN (64) | Faulting virtual address |
| sr_bev | input | 1 | Boot vectors selected |
| sr_ux | input | 1 | Wide addressing, user region |
| sr_sx | input | 1 | Wide addressing, supervisor region |
| sr_kx | input | 1 | Wide addressing, kernel region |
| exl_clr | input | 1 | Clear the exception level |
| exl | output | 1 | Exception level flag |
| epc | output | XLEN (64) | Exception program counter |
| cause_bd | output | 1 | Cause branch-delay flag |
| cause_code | output | CODE_W (5) | Cause exception code |
| cause_ce | output | 2 | Cause coprocessor number |
| badvaddr | output | XLEN (64) | Faulting address register |
| ctx_vpn2 | output | CTX_VPN2_W (19) | Narrow context page field |
| xctx_vpn2 | output | XCTX_VPN2_W (27) | Wide context page field |
| xctx_region | output | 2 | Wide context region field |
| ehi_vpn2 | output | XCTX_VPN2_W (27) | Entry-high page field |
| ehi_region | output | 2 | Entry-high region field |
| pc_load | output | 1 | Load `new_pc` into the PC |
| new_pc | output | XLEN (64) | Handler address |
| bev_err | output | 1 | Strobe taken while boot vectors selected |

## Verification
Every result is registered, so it appears one rising edge after the cycle in which the strobe is high. The bench drives each strobe on a falling edge and compares every output at the next falling edge, half a period after the update. One cycle later it checks again to confirm that `pc_load` and `bev_err` have dropped. Clearing `exl` is also one edge long, so every sweep point is preceded either by a clear pulse or by a preparatory exception. This puts a known exception level in place before the strobe under test.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [2:0] {
      TE_NONE    = 3'd0,
      TE_MISS    = 3'd1,
      TE_INVALID = 3'd2,
      TE_MODIFY  = 3'd3,
      TE_BADADDR = 3'd4
   } tlb_err_e;

   localparam int          CODE_MIN_W = 5;
   localparam logic [4:0]  EC_MOD  = 5'd1;
   localparam logic [4:0]  EC_TLBL = 5'd2;
   localparam logic [4:0]  EC_TLBS = 5'd3;
   localparam logic [4:0]  EC_ADEL = 5'd4;
   localparam logic [4:0]  EC_ADES = 5'd5;
endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
   import exc_entry_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic [2:0]        tlb_err,
   input  logic              is_store,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_out,
   output logic              tlb_fault,
   output logic              err_invalid
);
   generate
      if (CODE_W < CODE_MIN_W) begin : g_bad_code_w
         $error("exc_code_map: CODE_W too narrow");
      end
   endgenerate

   always_comb begin
      tlb_fault   = 1'b1;
      err_invalid = (tlb_err == TE_INVALID);
      case (tlb_err)
         TE_MISS, TE_INVALID: code_out = is_store ? CODE_W'(EC_TLBS) : CODE_W'(EC_TLBL);
         TE_MODIFY:           code_out = CODE_W'(EC_MOD);
         TE_BADADDR:          code_out = is_store ? CODE_W'(EC_ADES) : CODE_W'(EC_ADEL);
         default: begin
            code_out  = code_in;
            tlb_fault = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_entry_pkg::*;
#(
   parameter int          XLEN         = 64,
   parameter int          CODE_W       = 5,
   parameter logic [31:0] VEC_GENERAL  = 32'h8000_0180,
   parameter logic [31:0] VEC_REFILL32 = 32'h8000_0000,
   parameter logic [31:0] VEC_REFILL64 = 32'h8000_0080,
   parameter bit          ADDR64_EN    = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              old_exl,
   input  logic              err_invalid,
   input  logic [1:0]        region,
   input  logic              ux,
   input  logic              sx,
   input  logic              kx,
   output logic [XLEN-1:0]   vec
);
   localparam int EXT_W = XLEN - 32;

   generate
      if (XLEN <= 32) begin : g_bad_xlen
         $error("exc_vector_sel: XLEN must exceed 32");
      end
   endgenerate

   logic        wide;
   logic        is_refill;
   logic [31:0] sel;

   generate
      if (ADDR64_EN) begin : g_wide
         always_comb begin
            case (region)
               2'b00:   wide = ux;
               2'b01:   wide = sx;
               2'b11:   wide = kx;
               default: wide = 1'b0;
            endcase
         end
      end else begin : g_narrow
         logic unused_mode;
         assign unused_mode = ^{region, ux, sx, kx};
         assign wide = 1'b0;
      end
   endgenerate

   always_comb begin
      is_refill = (code == CODE_W'(EC_TLBL)) || (code == CODE_W'(EC_TLBS));
      if (is_refill && !old_exl && !err_invalid)
         sel = wide ? VEC_REFILL64 : VEC_REFILL32;
      else
         sel = VEC_GENERAL;
      vec = {{EXT_W{sel[31]}}, sel};
   end
endmodule

// File: rtl/exc_fault_regs.sv
module exc_fault_regs #(
   parameter int XLEN        = 64,
   parameter int PAGE_SHIFT  = 13,
   parameter int CTX_VPN2_W  = 19,
   parameter int XCTX_VPN2_W = 27
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   capture,
   input  logic [XLEN-1:0]        vaddr,
   output logic [XLEN-1:0]        badvaddr,
   output logic [CTX_VPN2_W-1:0]  ctx_vpn2,
   output logic [XCTX_VPN2_W-1:0] xctx_vpn2,
   output logic [1:0]             xctx_region,
   output logic [XCTX_VPN2_W-1:0] ehi_vpn2,
   output logic [1:0]             ehi_region
);
   localparam int CTX_HI  = PAGE_SHIFT + CTX_VPN2_W - 1;
   localparam int XCTX_HI = PAGE_SHIFT + XCTX_VPN2_W - 1;

   generate
      if (XCTX_HI >= XLEN - 2 || CTX_HI > XCTX_HI) begin : g_bad_fields
         $error("exc_fault_regs: page fields do not fit the address");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         badvaddr    <= '0;
         ctx_vpn2    <= '0;
         xctx_vpn2   <= '0;
         xctx_region <= '0;
         ehi_vpn2    <= '0;
         ehi_region  <= '0;
      end else if (capture) begin
         badvaddr    <= vaddr;
         ctx_vpn2    <= vaddr[CTX_HI:PAGE_SHIFT];
         xctx_vpn2   <= vaddr[XCTX_HI:PAGE_SHIFT];
         xctx_region <= vaddr[XLEN-1:XLEN-2];
         ehi_vpn2    <= vaddr[XCTX_HI:PAGE_SHIFT];
         ehi_region  <= vaddr[XLEN-1:XLEN-2];
      end
   end
endmodule

// File: rtl/exc_entry.sv
module exc_entry #(
   parameter int          XLEN         = 64,
   parameter int          CODE_W       = 5,
   parameter int          PAGE_SHIFT   = 13,
   parameter int          CTX_VPN2_W   = 19,
   parameter int          XCTX_VPN2_W  = 27,
   parameter int          INSN_BYTES   = 4,
   parameter logic [31:0] VEC_GENERAL  = 32'h8000_0180,
   parameter logic [31:0] VEC_REFILL32 = 32'h8000_0000,
   parameter logic [31:0] VEC_REFILL64 = 32'h8000_0080,
   parameter bit          ADDR64_EN    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   exc_valid,
   input  logic [CODE_W-1:0]      exc_code,
   input  logic [1:0]             exc_cop,
   input  logic [XLEN-1:0]        exc_pc,
   input  logic                   exc_in_delay,
   input  logic [2:0]             tlb_err,
   input  logic                   acc_store,
   input  logic [XLEN-1:0]        fault_va,
   input  logic                   sr_bev,
   input  logic                   sr_ux,
   input  logic                   sr_sx,
   input  logic                   sr_kx,
   input  logic                   exl_clr,
   output logic                   exl,
   output logic [XLEN-1:0]        epc,
   output logic                   cause_bd,
   output logic [CODE_W-1:0]      cause_code,
   output logic [1:0]             cause_ce,
   output logic [XLEN-1:0]        badvaddr,
   output logic [CTX_VPN2_W-1:0]  ctx_vpn2,
   output logic [XCTX_VPN2_W-1:0] xctx_vpn2,
   output logic [1:0]             xctx_region,
   output logic [XCTX_VPN2_W-1:0] ehi_vpn2,
   output logic [1:0]             ehi_region,
   output logic                   pc_load,
   output logic [XLEN-1:0]        new_pc,
   output logic                   bev_err
);
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(INSN_BYTES);

   logic [CODE_W-1:0] final_code;
   logic              tlb_fault;
   logic              err_invalid;
   logic [XLEN-1:0]   vec;

   exc_code_map #(.CODE_W(CODE_W)) u_map (
      .tlb_err     (tlb_err),
      .is_store    (acc_store),
      .code_in     (exc_code),
      .code_out    (final_code),
      .tlb_fault   (tlb_fault),
      .err_invalid (err_invalid)
   );

   exc_vector_sel #(
      .XLEN(XLEN), .CODE_W(CODE_W), .VEC_GENERAL(VEC_GENERAL),
      .VEC_REFILL32(VEC_REFILL32), .VEC_REFILL64(VEC_REFILL64), .ADDR64_EN(ADDR64_EN)
   ) u_vec (
      .code        (final_code),
      .old_exl     (exl),
      .err_invalid (err_invalid),
      .region      (fault_va[XLEN-1:XLEN-2]),
      .ux          (sr_ux),
      .sx          (sr_sx),
      .kx          (sr_kx),
      .vec         (vec)
   );

   exc_fault_regs #(
      .XLEN(XLEN), .PAGE_SHIFT(PAGE_SHIFT),
      .CTX_VPN2_W(CTX_VPN2_W), .XCTX_VPN2_W(XCTX_VPN2_W)
   ) u_fault (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (exc_valid && tlb_fault),
      .vaddr       (fault_va),
      .badvaddr    (badvaddr),
      .ctx_vpn2    (ctx_vpn2),
      .xctx_vpn2   (xctx_vpn2),
      .xctx_region (xctx_region),
      .ehi_vpn2    (ehi_vpn2),
      .ehi_region  (ehi_region)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exl        <= 1'b0;
         epc        <= '0;
         cause_bd   <= 1'b0;
         cause_code <= '0;
         cause_ce   <= '0;
         pc_load    <= 1'b0;
         new_pc     <= '0;
         bev_err    <= 1'b0;
      end else if (exc_valid) begin
         cause_code <= final_code;
         cause_ce   <= exc_cop;
         if (!exl) begin
            cause_bd <= exc_in_delay;
            epc      <= exc_in_delay ? exc_pc - PC_STEP : exc_pc;
         end
         exl     <= 1'b1;
         pc_load <= !sr_bev;
         bev_err <= sr_bev;
         if (!sr_bev)
            new_pc <= vec;
      end else begin
         pc_load <= 1'b0;
         bev_err <= 1'b0;
         if (exl_clr)
            exl <= 1'b0;
      end
   end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int          XLEN         = 64,
   parameter logic [31:0] VEC_GENERAL  = 32'h8000_0180,
   parameter logic [31:0] VEC_REFILL32 = 32'h8000_0000,
   parameter logic [31:0] VEC_REFILL64 = 32'h8000_0080
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exc_valid,
   input logic            exl_clr,
   input logic            sr_bev,
   input logic [2:0]      tlb_err,
   input logic            exl,
   input logic [XLEN-1:0] epc,
   input logic            cause_bd,
   input logic [XLEN-1:0] badvaddr,
   input logic            pc_load,
   input logic [XLEN-1:0] new_pc,
   input logic            bev_err
);
   localparam logic [XLEN-1:0] V_G  = {{(XLEN-32){VEC_GENERAL[31]}},  VEC_GENERAL};
   localparam logic [XLEN-1:0] V_32 = {{(XLEN-32){VEC_REFILL32[31]}}, VEC_REFILL32};
   localparam logic [XLEN-1:0] V_64 = {{(XLEN-32){VEC_REFILL64[31]}}, VEC_REFILL64};

   logic no_err_class;
   assign no_err_class = (tlb_err == 3'd0) || (tlb_err > 3'd4);

   assert_exl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> exl);

   assert_epc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exl) |=> ($stable(epc) && $stable(cause_bd)));

   assert_vec_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (new_pc == V_G || new_pc == V_32 || new_pc == V_64));

   assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && no_err_class) |=> $stable(badvaddr));

   assert_bev_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && sr_bev) |=> (bev_err && !pc_load));

   assert_pc_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> ($past(exc_valid) && !$past(sr_bev)));

   assert_exl_clr_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (exl_clr && !exc_valid) |=> !exl);
endmodule

bind exc_entry exc_entry_chk #(
   .XLEN(XLEN), .VEC_GENERAL(VEC_GENERAL),
   .VEC_REFILL32(VEC_REFILL32), .VEC_REFILL64(VEC_REFILL64)
) u_chk (
   .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exl_clr(exl_clr),
   .sr_bev(sr_bev), .tlb_err(tlb_err), .exl(exl), .epc(epc),
   .cause_bd(cause_bd), .badvaddr(badvaddr), .pc_load(pc_load),
   .new_pc(new_pc), .bev_err(bev_err)
);

// File: tb/exc_entry_test.sv
`timescale 1ns/1ps
module exc_entry_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [4:0]  exc_code = '0;
   logic [1:0]  exc_cop = '0;
   logic [63:0] exc_pc = '0;
   logic        exc_in_delay = 1'b0;
   logic [2:0]  tlb_err = '0;
   logic        acc_store = 1'b0;
   logic [63:0] fault_va = '0;
   logic        sr_bev = 1'b0, sr_ux = 1'b0, sr_sx = 1'b0, sr_kx = 1'b0;
   logic        exl_clr = 1'b0;
   logic        exl, cause_bd, pc_load, bev_err;
   logic [63:0] epc, badvaddr, new_pc;
   logic [4:0]  cause_code;
   logic [1:0]  cause_ce, xctx_region, ehi_region;
   logic [18:0] ctx_vpn2;
   logic [26:0] xctx_vpn2, ehi_vpn2;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // bench model of the architectural state
   logic        m_exl = 0, m_bd = 0;
   logic [63:0] m_epc = 0, m_bv = 0;
   logic [18:0] m_ctx = 0;
   logic [26:0] m_xv = 0;
   logic [1:0]  m_xr = 0;

   localparam logic [63:0] V_G  = 64'hFFFF_FFFF_8000_0180;
   localparam logic [63:0] V_32 = 64'hFFFF_FFFF_8000_0000;
   localparam logic [63:0] V_64 = 64'hFFFF_FFFF_8000_0080;

   always #2.5 clk = ~clk;

   exc_entry uut (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
      .exc_cop(exc_cop), .exc_pc(exc_pc), .exc_in_delay(exc_in_delay),
      .tlb_err(tlb_err), .acc_store(acc_store), .fault_va(fault_va),
      .sr_bev(sr_bev), .sr_ux(sr_ux), .sr_sx(sr_sx), .sr_kx(sr_kx),
      .exl_clr(exl_clr), .exl(exl), .epc(epc), .cause_bd(cause_bd),
      .cause_code(cause_code), .cause_ce(cause_ce), .badvaddr(badvaddr),
      .ctx_vpn2(ctx_vpn2), .xctx_vpn2(xctx_vpn2), .xctx_region(xctx_region),
      .ehi_vpn2(ehi_vpn2), .ehi_region(ehi_region), .pc_load(pc_load),
      .new_pc(new_pc), .bev_err(bev_err)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_code(input logic [2:0] e, input logic st, input logic [4:0] c);
      case (e)
         3'd1, 3'd2: return st ? 5'd3 : 5'd2;
         3'd3:       return 5'd1;
         3'd4:       return st ? 5'd5 : 5'd4;
         default:    return c;
      endcase
   endfunction

   task automatic pulse_clr();
      @(negedge clk);
      exl_clr = 1'b1;
      @(negedge clk);
      exl_clr = 1'b0;
      m_exl = 1'b0;
      chk(64'(exl), 64'd0, "R14 exl cleared");
   endtask

   task automatic do_exc(input logic [4:0] c, input logic [1:0] cop, input logic [63:0] pc,
                         input logic dly, input logic [2:0] e, input logic st,
                         input logic [63:0] va, input logic bev, input logic [2:0] mode);
      logic        old;
      logic [4:0]  ec;
      logic        wide;
      logic [63:0] ev;
      string       vtag, ctag;
      old  = m_exl;
      ec   = exp_code(e, st, c);
      case (va[63:62])
         2'b00:   wide = mode[0];
         2'b01:   wide = mode[1];
         2'b11:   wide = mode[2];
         default: wide = 1'b0;
      endcase
      if (ec == 5'd2 || ec == 5'd3) begin
         if (old || e == 3'd2) begin ev = V_G; vtag = "R8 vector"; end
         else begin ev = wide ? V_64 : V_32; vtag = "R9 vector"; end
      end else begin
         ev = V_G; vtag = "R7 vector";
      end
      ctag = (e == 3'd0 || e > 3'd4) ? "R4 code" :
             (e == 3'd3 || e == 3'd4) ? "R6 code" : "R5 code";
      if (!old) begin
         m_bd  = dly;
         m_epc = dly ? pc - 64'd4 : pc;
      end
      m_exl = 1'b1;
      if (e >= 3'd1 && e <= 3'd4) begin
         m_bv  = va;
         m_ctx = va[31:13];
         m_xv  = va[39:13];
         m_xr  = va[63:62];
      end
      @(negedge clk);
      exc_valid = 1'b1; exc_code = c; exc_cop = cop; exc_pc = pc; exc_in_delay = dly;
      tlb_err = e; acc_store = st; fault_va = va; sr_bev = bev;
      {sr_kx, sr_sx, sr_ux} = mode;
      @(negedge clk);
      exc_valid = 1'b0;
      chk(64'(exl), 64'd1, "R2 exl set");
      chk(epc, m_epc, old ? "R3 epc held" : "R2 epc");
      chk(64'(cause_bd), 64'(m_bd), old ? "R3 bd held" : "R2 bd");
      chk(64'(cause_ce), 64'(cop), "R3 cop");
      chk(64'(cause_code), 64'(ec), ctag);
      if (bev) begin
         chk(64'(pc_load), 64'd0, "R12 no pc load");
         chk(64'(bev_err), 64'd1, "R12 bev flag");
      end else begin
         chk(64'(pc_load), 64'd1, "R13 pc load");
         chk(new_pc, ev, vtag);
      end
      chk(badvaddr, m_bv, (e >= 3'd1 && e <= 3'd4) ? "R10 badvaddr" : "R11 badvaddr");
      chk(64'(ctx_vpn2), 64'(m_ctx), "R10 ctx");
      chk(64'(xctx_vpn2), 64'(m_xv), "R10 xctx vpn2");
      chk(64'(ehi_vpn2), 64'(m_xv), "R10 ehi vpn2");
      chk(64'(xctx_region), 64'(m_xr), "R10 xctx region");
      chk(64'(ehi_region), 64'(m_xr), "R10 ehi region");
      @(negedge clk);
      chk(64'(pc_load), 64'd0, "R13 pulse ends");
      chk(64'(bev_err), 64'd0, "R12 pulse ends");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int i = 0;
      logic [4:0] codes [8] = '{5'd0, 5'd2, 5'd3, 5'd8, 5'd10, 5'd12, 5'd15, 5'd23};
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(64'(exl), 0, "R1 exl"); chk(epc, 0, "R1 epc"); chk(64'(cause_bd), 0, "R1 bd");
      chk(64'(cause_code), 0, "R1 code"); chk(64'(cause_ce), 0, "R1 ce");
      chk(badvaddr, 0, "R1 badvaddr"); chk(64'(ctx_vpn2), 0, "R1 ctx");
      chk(64'({xctx_vpn2, xctx_region, ehi_vpn2, ehi_region}), 0, "R1 context");
      chk(64'(pc_load), 0, "R1 pc_load"); chk(new_pc, 0, "R1 new_pc");
      chk(64'(bev_err), 0, "R1 bev_err");
      rst_n = 1'b1;
      @(negedge clk);

      for (int oe = 0; oe < 2; oe++)
         for (int e = 0; e < 5; e++)
            for (int st = 0; st < 2; st++)
               for (int r = 0; r < 4; r++)
                  for (int m = 0; m < 8; m++)
                     for (int d = 0; d < 2; d++) begin
                        logic [63:0] va;
                        i++;
                        va = {r[1:0], 62'(64'(i) * 64'h9E37_79B9_7F4A_7C15)};
                        if (oe == 0) pulse_clr();
                        else if (!m_exl)
                           do_exc(5'd8, 2'd0, 64'hFFFF_FFFF_8000_4000, 1'b0, 3'd0, 1'b0,
                                  64'd0, 1'b0, 3'd0);
                        do_exc(codes[m], 2'(i), 64'hFFFF_FFFF_8000_0000 + 64'(i) * 8,
                               d[0], e[2:0], st[0], va, 1'b0, m[2:0]);
                     end

      // R4: error classes 5..7 behave as none
      pulse_clr();
      do_exc(5'd13, 2'd1, 64'h0000_0000_0040_0010, 1'b0, 3'd6, 1'b1,
             64'h1234_5678_9ABC_DEF0, 1'b0, 3'd7);

      // R12: boot vectors selected, state still updates
      pulse_clr();
      do_exc(5'd0, 2'd3, 64'hFFFF_FFFF_8000_2000, 1'b1, 3'd1, 1'b0,
             64'h4000_0000_0001_E000, 1'b1, 3'd7);
      do_exc(5'd9, 2'd0, 64'hFFFF_FFFF_8000_3000, 1'b0, 3'd0, 1'b0,
             64'd0, 1'b1, 3'd0);

      // R14: strobe and clear in the same cycle, strobe wins
      pulse_clr();
      @(negedge clk);
      exc_valid = 1'b1; exl_clr = 1'b1; tlb_err = 3'd0; exc_code = 5'd8; sr_bev = 1'b0;
      @(negedge clk);
      exc_valid = 1'b0; exl_clr = 1'b0;
      chk(64'(exl), 64'd1, "R14 strobe wins over clear");
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule